// File: doc/BRIEF.md
# Batch-Aligned Sample Timestamp Counter

This block stamps each batch of converter samples with a time value taken from a slow external reference clock. The reference input is brought into the system clock domain, and its rising edges are divided by four. Each fourth edge advances a free-running counter. The counter returns to zero after it reaches a programmable top value, which is normally chosen so that the counter wraps once per batch.

A per-sample strobe from the first converter channel drives the capture. The strobe passes through a prescaler that counts up to the batch length. The counter is therefore sampled only on the strobe of the final sample of each batch, which gives one capture per batch.

Each new captured value is announced by a one-cycle valid pulse. The consumer acknowledges it with a one-cycle acknowledge input. If a new capture arrives before the previous one was acknowledged, a sticky overflow flag is set. The batch length and the top value are taken from the inputs only while the block is disabled.

Top module: `batch_stamp`

## Requirements
- R1: While enabled, the counter advances by one on every fourth rising edge of `ref_clk_in`, counted after synchronisation. The divider phase starts at zero each time the block is enabled.
- R2: When the counter advances from a value equal to the latched top value, it goes to 0 instead.
- R3: A capture happens on every `batch_len`-th asserted `sample_stb` while enabled, counted from enable. In the cycle after that strobe, `stamp` holds the counter value that was current in the strobe cycle. Between captures, `stamp` keeps its value.
- R4: A latched batch length of 0 or 1 makes every strobe a capture.
- R5: `stamp_vld` is high for exactly the one cycle after each capturing strobe, and low otherwise.
- R6: `overflow` is set when a capture occurs while an earlier capture is still unacknowledged. An `ack` high in the same cycle as the new capture counts as acknowledging the earlier one. Once set, `overflow` stays set until reset. Disabling the block clears the pending state.
- R7: While `en` is low, the counter, the divider phase and the prescaler count are held at 0, and strobes cause no capture. `stamp` and `overflow` keep their values.
- R8: `batch_len` and `wrap_max` are latched on every cycle in which `en` is low. Changes to them while `en` is high have no effect.
- R9: After a synchronous reset, `stamp` is 0 and `stamp_vld` and `overflow` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable; configuration is latched while low |
| ref_clk_in | input | 1 | Asynchronous external reference clock |
| sample_stb | input | 1 | One-cycle strobe per sample of the first channel |
| batch_len | input | BW | Samples per batch (0 is treated as 1) |
| wrap_max | input | CW | Counter top value before wrapping to 0 |
| ack | input | 1 | Acknowledges the current captured value |
| stamp | output | CW | Captured counter value |
| stamp_vld | output | 1 | One-cycle pulse announcing a new capture |
| overflow | output | 1 | Sticky flag for a capture lost before acknowledge |

## Verification
The bench builds the block with a 6-bit counter and a 3-bit batch length. With these widths, top values of 5 and 2 make the counter wrap many times in a short run. Batch lengths of 4, 1 and 0 cover the prescaler's normal and degenerate settings. The reference toggles every three system clocks, so the synchroniser, the divide-by-four phase and the strobe timing interleave in many relative alignments. Withholding acknowledge while batches are short reaches the overflow path quickly.

// File: rtl/bstamp_pkg.sv
package bstamp_pkg;
  // reference edges per counter advance
  localparam int REF_DIV = 4;
  localparam int REF_DIV_W = $clog2(REF_DIV);
  // synchroniser depth before edge detection
  localparam int SYNC_STAGES = 2;
endpackage

// File: rtl/ref_edge_sync.sv
module ref_edge_sync
  import bstamp_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic ref_in,
  output logic rise
);
  // SYNC_STAGES flops plus one history flop for edge detection
  logic [SYNC_STAGES:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= '0;
    else     sh <= {sh[SYNC_STAGES-1:0], ref_in};
  end

  assign rise = sh[SYNC_STAGES-1] & ~sh[SYNC_STAGES];
endmodule

// File: rtl/ref_tick_counter.sv
module ref_tick_counter
  import bstamp_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          rise,
  input  logic [CW-1:0] wrap,
  output logic [CW-1:0] count,
  output logic          tick
);
  logic [REF_DIV_W-1:0] phase;

  assign tick = en & rise & (phase == REF_DIV_W'(REF_DIV - 1));

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      phase <= '0;
      count <= '0;
    end else begin
      if (rise) phase <= tick ? '0 : phase + 1'b1;
      if (tick) count <= (count == wrap) ? '0 : count + 1'b1;
    end
  end

  // R1: the counter moves only on a divided reference tick
  p_hold_r1: assert property (@(posedge clk) disable iff (rst)
    (en && !tick) |=> $stable(count));
  // R2: the counter never passes the latched top value
  p_wrap_r2: assert property (@(posedge clk) disable iff (rst)
    en |-> (count <= wrap));
endmodule

// File: rtl/batch_prescaler.sv
module batch_prescaler #(
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          stb,
  input  logic [BW-1:0] batch,
  output logic          trig
);
  logic [BW-1:0] pcnt;
  logic [BW:0]   nxt;

  assign nxt  = {1'b0, pcnt} + 1'b1;
  // a batch of 0 behaves as 1: nxt is always at least 1
  assign trig = en & stb & (nxt >= {1'b0, batch});

  always_ff @(posedge clk) begin
    if (rst || !en)  pcnt <= '0;
    else if (stb)    pcnt <= trig ? '0 : nxt[BW-1:0];
  end

  // R7: no trigger while disabled or without a strobe
  p_idle_r7: assert property (@(posedge clk) disable iff (rst)
    trig |-> (en && stb));
endmodule

// File: rtl/batch_stamp.sv
module batch_stamp #(
  parameter int CW = 16,
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          ref_clk_in,
  input  logic          sample_stb,
  input  logic [BW-1:0] batch_len,
  input  logic [CW-1:0] wrap_max,
  input  logic          ack,
  output logic [CW-1:0] stamp,
  output logic          stamp_vld,
  output logic          overflow
);
  logic [BW-1:0] cfg_batch;
  logic [CW-1:0] cfg_wrap;
  logic          rise, tick, trig, pend;
  logic [CW-1:0] count;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_batch <= '0;
      cfg_wrap  <= '0;
    end else if (!en) begin
      cfg_batch <= batch_len;
      cfg_wrap  <= wrap_max;
    end
  end

  ref_edge_sync u_sync (.clk(clk), .rst(rst), .ref_in(ref_clk_in), .rise(rise));

  ref_tick_counter #(.CW(CW)) u_cnt (
    .clk(clk), .rst(rst), .en(en), .rise(rise),
    .wrap(cfg_wrap), .count(count), .tick(tick)
  );

  batch_prescaler #(.BW(BW)) u_pre (
    .clk(clk), .rst(rst), .en(en), .stb(sample_stb),
    .batch(cfg_batch), .trig(trig)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      stamp     <= '0;
      stamp_vld <= 1'b0;
      overflow  <= 1'b0;
      pend      <= 1'b0;
    end else begin
      stamp_vld <= trig;
      if (trig) stamp <= count;
      if (trig && pend && !ack) overflow <= 1'b1;
      pend <= en & (trig | (pend & ~ack));
    end
  end

  // R3: the capture holds the count seen on the strobe
  p_stamp_r3: assert property (@(posedge clk) disable iff (rst)
    trig |=> (stamp == $past(count)));
  // R5: each capture is announced in the next cycle
  p_vld_r5: assert property (@(posedge clk) disable iff (rst)
    trig |=> stamp_vld);
  // R6: overflow is sticky
  p_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    overflow |=> overflow);
  // R8: configuration frozen while enabled
  p_cfg_r8: assert property (@(posedge clk) disable iff (rst)
    en |=> ($stable(cfg_batch) && $stable(cfg_wrap)));
endmodule

// File: tb/batch_stamp_test.sv
module batch_stamp_test;
  localparam int CW = 6;
  localparam int BW = 3;

  logic clk = 0, rst = 1, en = 0, ref_clk_in = 0, sample_stb = 0, ack = 0;
  logic [BW-1:0] batch_len = '0;
  logic [CW-1:0] wrap_max = '0;
  logic [CW-1:0] stamp;
  logic stamp_vld, overflow;

  batch_stamp #(.CW(CW), .BW(BW)) uut (
    .clk(clk), .rst(rst), .en(en), .ref_clk_in(ref_clk_in),
    .sample_stb(sample_stb), .batch_len(batch_len), .wrap_max(wrap_max),
    .ack(ack), .stamp(stamp), .stamp_vld(stamp_vld), .overflow(overflow)
  );

  always #5 clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 0;
  string tag = "R9";
  bit auto_ack = 1;
  int refc = 0;

  // behavioural reference model
  int ref_hist[$];
  int m_edges, m_cnt, m_pcnt, m_cfg_b, m_cfg_w;
  int e_stamp, e_vld, e_ovf, m_pend;

  always @(posedge clk) begin
    if (rst) begin
      ref_hist = {0, 0, 0};
      m_edges = 0; m_cnt = 0; m_pcnt = 0; m_cfg_b = 0; m_cfg_w = 0;
      e_stamp = 0; e_vld = 0; e_ovf = 0; m_pend = 0;
    end else begin
      int rise_seen, fire, blen;
      rise_seen = (ref_hist[$-1] == 1 && ref_hist[$-2] == 0);
      blen = (m_cfg_b == 0) ? 1 : m_cfg_b;
      fire = en && sample_stb && (m_pcnt + 1 >= blen);
      e_vld = fire;
      if (fire) e_stamp = m_cnt;
      if (fire && m_pend && !ack) e_ovf = 1;
      m_pend = en && (fire || (m_pend && !ack));
      if (!en) begin
        m_edges = 0; m_cnt = 0; m_pcnt = 0;
        m_cfg_b = batch_len; m_cfg_w = wrap_max;
      end else begin
        if (rise_seen) begin
          m_edges++;
          if (m_edges == 4) begin
            m_edges = 0;
            m_cnt = (m_cnt == m_cfg_w) ? 0 : m_cnt + 1;
          end
        end
        if (sample_stb) m_pcnt = fire ? 0 : m_pcnt + 1;
      end
      ref_hist.push_back(int'(ref_clk_in));
      if (ref_hist.size() > 8) void'(ref_hist.pop_front());
    end
  end

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // one cycle: compare at the falling edge, then drive the next inputs
  task automatic step(bit stb);
    @(negedge clk);
    check(tag, int'(stamp), e_stamp);
    check("R5", int'(stamp_vld), e_vld);
    check("R6", int'(overflow), e_ovf);
    ack = auto_ack & stamp_vld;
    sample_stb = stb;
    refc++;
    if (refc == 3) begin refc = 0; ref_clk_in = ~ref_clk_in; end
  endtask

  task automatic run(int n, int gap);
    for (int i = 0; i < n; i++) step((gap > 0) && (i % gap == gap - 1));
  endtask

  task automatic reconfig(int b, int w);
    en = 0; step(0);
    batch_len = BW'(b); wrap_max = CW'(w); step(0); step(0);
    en = 1;
  endtask

  initial begin
    run(4, 0);
    rst = 0;
    tag = "R9"; run(3, 0);               // reset state
    tag = "R1"; reconfig(4, 5); run(400, 7);
    tag = "R2"; reconfig(4, 2); run(300, 5);
    tag = "R3"; reconfig(3, 40); run(300, 4);
    tag = "R4"; reconfig(1, 9); run(120, 3);
    reconfig(0, 9); run(120, 2);
    tag = "R8"; batch_len = 3'd6; wrap_max = 6'd1; run(150, 3);
    tag = "R7"; en = 0; run(100, 2);
    tag = "R6"; auto_ack = 0; reconfig(1, 7); run(60, 4);
    auto_ack = 1; run(40, 5);
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    #1000000;
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule